// File: doc/BRIEF.md
# Haar Wavelet Pair Decomposer

This block performs a single level of a Haar-style discrete wavelet transform over a small fixed buffer of unsigned samples. A one-cycle start pulse begins a pass. The block walks through the buffer two samples at a time. For each pair it forms the half-sum (the approximation) and the half-difference (the detail). It multiplies both by a fixed-point square-root-of-two gain and presents the two results together as one beat on a valid/ready output stream.

All arithmetic uses fixed-point integers with eight fraction bits. The halving keeps its fractional bit instead of truncating, and the detail value is signed. After the last pair's beat has been accepted, the block pulses `done` for one cycle and returns to idle. The next start replays the buffer from its first pair.

Top module: `haar_dwt_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` and `done` are 0. No beat is offered until a start is seen.
- R2: A start pulse seen while idle makes `out_valid` go high on the next cycle, carrying the pair made of samples 0 and 1. The buffer contents are 4, 6, 10, 12, 8, 6, 5, 6.
- R3: The approximation of pair (a, b) equals floor(((a+b)·128·362 + 128) / 256). This is (a+b)/2 in signed Q.8 with the half bit kept, multiplied by 0x16A/256 and rounded half-up back to Q.8.
- R4: The detail of pair (a, b) is signed. It equals floor(((a−b)·128·362 + 128) / 256) and is negative when b > a.
- R5: Each beat packs the approximation in bits [33:17] and the detail in bits [16:0]. Both are 17-bit two's-complement values with 8 fraction bits.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_beat` does not change.
- R7: Pairs are emitted in buffer order, one pair per accepted beat (`out_valid` and `out_ready` both high). The pair position advances only on acceptance, so back-to-back beats flow when `out_ready` stays high.
- R8: After the fourth beat of a pass is accepted, `out_valid` drops and `done` is high for exactly one cycle.
- R9: A start pulse seen while a pass is in progress has no effect on the beats or on `done`.
- R10: Each new pass begins again at the first pair and yields identical beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when the block is idle |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A coefficient beat is offered |
| out_beat | output | 34 | Approximation in the upper half, detail in the lower half |
| done | output | 1 | One-cycle pulse after the final beat of a pass is accepted |

## Verification
Some properties are checked by assertions on every cycle. One is that a stalled beat holds its value and its valid flag. Another is that the pair position moves only on acceptance, so a start that arrives mid-pass is ignored. A third is that `done` is a single-cycle pulse that follows an accepted beat and leaves the stream idle. The arithmetic cannot be shown by those properties. The bench's reference model checks it with the rounding of negative details and the kept half bit, for every pair. The bench also shows, through its scenarios, the ordering under irregular ready patterns, a start held high across the end of a pass, and the replay of each new pass from the first pair.

// File: rtl/haar_pkg.sv
package haar_pkg;

    localparam int DEF_SAMPLE_W    = 7;
    localparam int DEF_NUM_SAMPLES = 8;
    localparam int DEF_FRAC_W      = 8;
    localparam int DEF_GAIN_W      = 16;
    localparam logic [DEF_GAIN_W-1:0] DEF_GAIN = 16'h016A;

    typedef enum logic {
        PASS_IDLE = 1'b0,
        PASS_RUN  = 1'b1
    } pass_state_t;

    function automatic int default_sample(input int pos);
        case (pos % 8)
            0: return 4;
            1: return 6;
            2: return 10;
            3: return 12;
            4: return 8;
            5: return 6;
            6: return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/haar_sample_store.sv
module haar_sample_store #(
    parameter int NUM_SAMPLES = haar_pkg::DEF_NUM_SAMPLES,
    parameter int SAMPLE_W    = haar_pkg::DEF_SAMPLE_W,
    localparam int ADDR_W     = $clog2(NUM_SAMPLES),
    localparam int PAIR_W     = ADDR_W - 1
) (
    input  logic [PAIR_W-1:0]   pair_idx,
    output logic [SAMPLE_W-1:0] first_smp,
    output logic [SAMPLE_W-1:0] second_smp
);
    logic [SAMPLE_W-1:0] table_q [NUM_SAMPLES];

    for (genvar g = 0; g < NUM_SAMPLES; g++) begin : g_fill
        assign table_q[g] = SAMPLE_W'(haar_pkg::default_sample(g));
    end

    assign first_smp  = table_q[{pair_idx, 1'b0}];
    assign second_smp = table_q[{pair_idx, 1'b1}];
endmodule

// File: rtl/haar_butterfly.sv
module haar_butterfly #(
    parameter int SAMPLE_W = haar_pkg::DEF_SAMPLE_W,
    parameter int FRAC_W   = haar_pkg::DEF_FRAC_W,
    localparam int INT_W   = SAMPLE_W + 2,
    localparam int COEF_W  = INT_W + FRAC_W
) (
    input  logic [SAMPLE_W-1:0]      smp_a,
    input  logic [SAMPLE_W-1:0]      smp_b,
    output logic signed [COEF_W-1:0] half_sum,
    output logic signed [COEF_W-1:0] half_diff
);
    logic [SAMPLE_W:0]        pair_sum;
    logic signed [SAMPLE_W:0] pair_diff;
    logic signed [INT_W-1:0]  sum_int;
    logic signed [INT_W-1:0]  diff_int;

    always_comb begin
        pair_sum  = {1'b0, smp_a} + {1'b0, smp_b};
        pair_diff = $signed({1'b0, smp_a}) - $signed({1'b0, smp_b});
        sum_int   = $signed({1'b0, pair_sum});
        diff_int  = {pair_diff[SAMPLE_W], pair_diff};
        // place integer above the fraction field, then halve arithmetically
        half_sum  = $signed({sum_int,  {FRAC_W{1'b0}}}) >>> 1;
        half_diff = $signed({diff_int, {FRAC_W{1'b0}}}) >>> 1;
    end
endmodule

// File: rtl/haar_gain.sv
module haar_gain #(
    parameter int COEF_W = haar_pkg::DEF_SAMPLE_W + 2 + haar_pkg::DEF_FRAC_W,
    parameter int FRAC_W = haar_pkg::DEF_FRAC_W,
    parameter int GAIN_W = haar_pkg::DEF_GAIN_W,
    parameter logic [GAIN_W-1:0] GAIN = haar_pkg::DEF_GAIN,
    localparam int PROD_W = COEF_W + GAIN_W + 1
) (
    input  logic signed [COEF_W-1:0] coef_in,
    output logic signed [COEF_W-1:0] coef_out
);
    localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(2 ** (FRAC_W - 1));
    localparam logic signed [PROD_W-1:0] GAIN_EXT = $signed(PROD_W'(GAIN));

    logic signed [PROD_W-1:0] coef_ext;
    logic signed [PROD_W-1:0] product;

    always_comb begin
        coef_ext = PROD_W'(coef_in);
        product  = coef_ext * GAIN_EXT;
        coef_out = COEF_W'((product + HALF_LSB) >>> FRAC_W);
    end
endmodule

// File: rtl/haar_pair_seq.sv
module haar_pair_seq #(
    parameter int NUM_PAIRS = haar_pkg::DEF_NUM_SAMPLES / 2,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             accept_i,
    output logic             load_o,
    output logic [IDX_W-1:0] load_idx_o,
    output logic             finish_o
);
    import haar_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);

    pass_state_t      st_q;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    always_comb begin
        at_last    = (idx_q == LAST_IDX);
        finish_o   = (st_q == PASS_RUN) && accept_i && at_last;
        load_o     = ((st_q == PASS_IDLE) && start_i) ||
                     ((st_q == PASS_RUN) && accept_i && !at_last);
        load_idx_o = (st_q == PASS_IDLE) ? '0 : IDX_W'(idx_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PASS_IDLE;
            idx_q <= '0;
        end else if (st_q == PASS_IDLE) begin
            if (start_i) begin
                st_q  <= PASS_RUN;
                idx_q <= '0;
            end
        end else if (accept_i) begin
            if (at_last) begin
                st_q <= PASS_IDLE;
            end else begin
                idx_q <= IDX_W'(idx_q + 1'b1);
            end
        end
    end

    // R7 R9
    property idx_hold_p;
        @(posedge clk) disable iff (rst)
        (st_q == PASS_RUN && !accept_i) |=> (st_q == PASS_RUN && idx_q == $past(idx_q));
    endproperty
    idx_hold_chk: assert property (idx_hold_p);

    // R7
    property accept_in_run_p;
        @(posedge clk) disable iff (rst)
        accept_i |-> (st_q == PASS_RUN);
    endproperty
    accept_in_run_chk: assert property (accept_in_run_p);

    // R10
    property restart_first_p;
        @(posedge clk) disable iff (rst)
        (st_q == PASS_IDLE && start_i) |=> (st_q == PASS_RUN && idx_q == '0);
    endproperty
    restart_first_chk: assert property (restart_first_p);
endmodule

// File: rtl/haar_dwt_core.sv
module haar_dwt_core #(
    parameter int NUM_SAMPLES = haar_pkg::DEF_NUM_SAMPLES,
    parameter int SAMPLE_W    = haar_pkg::DEF_SAMPLE_W,
    parameter int FRAC_W      = haar_pkg::DEF_FRAC_W,
    parameter int GAIN_W      = haar_pkg::DEF_GAIN_W,
    parameter logic [GAIN_W-1:0] GAIN = haar_pkg::DEF_GAIN,
    localparam int NUM_PAIRS  = NUM_SAMPLES / 2,
    localparam int IDX_W      = $clog2(NUM_PAIRS),
    localparam int COEF_W     = SAMPLE_W + 2 + FRAC_W,
    localparam int BEAT_W     = 2 * COEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BEAT_W-1:0] out_beat,
    output logic              done
);
    logic                     accept;
    logic                     load;
    logic                     finish;
    logic [IDX_W-1:0]         load_idx;
    logic [SAMPLE_W-1:0]      smp_a;
    logic [SAMPLE_W-1:0]      smp_b;
    logic signed [COEF_W-1:0] half_c [2];
    logic signed [COEF_W-1:0] gain_c [2];
    logic                     valid_q;
    logic [BEAT_W-1:0]        beat_q;
    logic                     done_q;

    assign accept = valid_q && out_ready;

    haar_pair_seq #(.NUM_PAIRS(NUM_PAIRS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .accept_i  (accept),
        .load_o    (load),
        .load_idx_o(load_idx),
        .finish_o  (finish)
    );

    haar_sample_store #(.NUM_SAMPLES(NUM_SAMPLES), .SAMPLE_W(SAMPLE_W)) u_store (
        .pair_idx  (load_idx),
        .first_smp (smp_a),
        .second_smp(smp_b)
    );

    haar_butterfly #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_bfly (
        .smp_a    (smp_a),
        .smp_b    (smp_b),
        .half_sum (half_c[0]),
        .half_diff(half_c[1])
    );

    for (genvar k = 0; k < 2; k++) begin : g_gain
        haar_gain #(
            .COEF_W(COEF_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .GAIN(GAIN)
        ) u_gain (
            .coef_in (half_c[k]),
            .coef_out(gain_c[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                valid_q <= 1'b1;
                beat_q  <= {gain_c[0], gain_c[1]};
            end else if (finish) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_beat  = beat_q;
    assign done      = done_q;

    // R6
    property stall_hold_p;
        @(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat));
    endproperty
    stall_hold_chk: assert property (stall_hold_p);

    // R8
    property done_single_p;
        @(posedge clk) disable iff (rst)
        done |=> !done;
    endproperty
    done_single_chk: assert property (done_single_p);

    // R8
    property done_after_accept_p;
        @(posedge clk) disable iff (rst)
        done |-> ($past(out_valid && out_ready) && !out_valid);
    endproperty
    done_after_accept_chk: assert property (done_after_accept_p);

    // R2
    property start_offers_p;
        @(posedge clk) disable iff (rst)
        (!out_valid && !done && start) |=> out_valid;
    endproperty
    start_offers_chk: assert property (start_offers_p);
endmodule

// File: tb/sim_haar_dwt_core.sv
`timescale 1ns/1ps
module sim_haar_dwt_core;
    localparam int CW = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    logic out_valid;
    logic [2*CW-1:0] out_beat;
    logic done;

    int checks = 0;
    int fails = 0;

    int samp [8] = '{4, 6, 10, 12, 8, 6, 5, 6};

    // reference model state (after the latest rising edge)
    bit m_busy = 0;
    bit m_valid = 0;
    bit m_done = 0;
    int m_idx = 0;
    int accepts_in_pass = 0;
    bit hold_pending = 0;
    logic [2*CW-1:0] held_beat;

    always #2.5 clk = ~clk;

    haar_dwt_core u0 (
        .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
        .out_valid(out_valid), .out_beat(out_beat), .done(done)
    );

    function automatic int scaled(input int x);
        int p;
        p = x * 128 * 362 + 128;
        return p >>> 8;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_valid = 0; m_done = 0; m_idx = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy = 1; m_valid = 1; m_idx = 0;
                end
            end else if (m_valid && out_ready) begin
                if (m_idx == 3) begin
                    m_busy = 0; m_valid = 0; m_done = 1;
                end else begin
                    m_idx++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int ea, ed, aa, ad;
            check(out_valid == m_valid, "R7", "valid", int'(out_valid), int'(m_valid));
            check(done == m_done, "R8", "done", int'(done), int'(m_done));
            if (hold_pending)
                check(out_beat == held_beat, "R6", "stalled beat changed", 0, 1);
            if (out_valid && m_valid) begin
                ea = scaled(samp[2*m_idx] + samp[2*m_idx+1]);
                ed = scaled(samp[2*m_idx] - samp[2*m_idx+1]);
                aa = $signed(out_beat[2*CW-1:CW]);
                ad = $signed(out_beat[CW-1:0]);
                check(aa == ea, "R3", "approx", aa, ea);
                check(ad == ed, "R4", "detail", ad, ed);
                check(out_beat == {CW'(ea), CW'(ed)}, "R5", "packing", 0, 1);
            end
            if (done) check(accepts_in_pass == 4, "R8", "beats before done",
                            accepts_in_pass, 4);
            if (done) accepts_in_pass = 0;
            hold_pending = out_valid && !out_ready;
            held_beat = out_beat;
            if (out_valid && out_ready) accepts_in_pass++;
        end
    end

    task automatic wait_done();
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (done) return;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 while reset is held
        check(out_valid == 0 && done == 0, "R1", "outputs in reset", int'(out_valid), 0);
        rst = 1'b0;
        out_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 0, "R1", "idle without start", int'(out_valid), 0);
        end

        // pass A: ready always high
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 first pair offered one cycle after start
        check(out_valid == 1, "R2", "valid after start", int'(out_valid), 1);
        check($signed(out_beat[2*CW-1:CW]) == scaled(10), "R2", "first approx",
              $signed(out_beat[2*CW-1:CW]), scaled(10));
        wait_done();

        // pass B: irregular ready, starts while busy (R9)
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            out_ready = (k % 3 != 1) && (k < 5 || k > 8);
            start = (k == 0) || (k == 6) || (k == 11);
        end
        start = 1'b0;
        out_ready = 1'b1;
        repeat (10) @(negedge clk);

        // pass C: start held high across pass end (R10 replay)
        start = 1'b1;
        wait_done();
        wait_done();
        start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);

        // long stall on first beat (R6)
        out_ready = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        out_ready = 1'b1;
        wait_done();
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule